// File: doc/BRIEF.md
# Bit-Serial Multiply-Accumulate Tap

This block is one tap of a low-power FIR filter built from bit-serial arithmetic. A two's-complement data word arrives one bit per clock, least significant bit first. It is multiplied by a 4-bit coefficient held on a parallel port. The product leaves the multiplier array as a serial bit stream, and a serial adder adds it to a second serial stream: the partial sum coming from the neighbouring tap. Each sum bit is shifted into a 16-bit result register. After sixteen bit-times the register holds the complete word, `(data * coef + addend) mod 2^16`.

The multiplier array has one AND gate and one full adder for each coefficient bit. Each full adder keeps its carry in a flip-flop of its own and feeds it back to its own carry input on the next bit-time. The partial sums ripple combinationally through the stages, so the longest combinational path grows with the coefficient width and not with the data width.

A one-cycle start pulse clears the bit counter, every stored carry and the data delay line. The tap then consumes exactly sixteen bits, raises ready, and holds its result until the next start. A parameter selects whether the top coefficient bit carries a positive or a negative weight.

Top module: `bsmac_tap`

## Requirements
- R1: After reset, ready is 1 and result is 0.
- R2: A start pulse clears the bit counter, all stored carries and the data delay line, so ready is 0 after the edge that samples start. A start while a word is still in progress abandons that word and begins a new one.
- R3: With COEF_SIGNED=0 the coefficient is an unsigned value from 0 to 15. Each partial product is the AND of a data bit and a coefficient bit, and the product stream equals data*coef modulo 2^16, with data taken as 16-bit two's complement.
- R4: With COEF_SIGNED=1, coefficient bit 3 has a weight of -8, so the coefficient covers -8 to 7, and the product is formed modulo 2^16 with that weight.
- R5: The serial adder forms sum = p XOR a XOR c and carry = majority(p, a, c) on each bit, and the completed result equals (data*coef + addend) modulo 2^16.
- R6: Bit k of data and of addend is the one presented on the k-th clock edge after the start edge (k = 0 to 15), the least significant bit first. Each new sum bit enters result bit 15, and the existing contents move one place toward bit 0.
- R7: Ready stays 0 for the first 15 edges after the start edge and is 1 from the 16th edge onward.
- R8: Once ready is 1, the data, addend and coefficient inputs have no effect: result and ready hold until the next start.
- R9: Every full adder registers its own carry for one clock and returns it to its own carry input. The carry is cleared when both addend inputs are 0 and set when both are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new word |
| coef | input | COEF_W (4) | Coefficient, held steady for the whole word |
| data_bit | input | 1 | Serial data operand, LSB first |
| addend_bit | input | 1 | Serial partial sum from the neighbouring tap, LSB first |
| ready | output | 1 | High when the sixteen bits of the word have been processed |
| result | output | RES_W (16) | Accumulated result word |

## Verification
The bench builds two instances with COEF_W=4 and RES_W=16, one with COEF_SIGNED=0 and one with COEF_SIGNED=1, and drives both from the same stimulus. This small configuration makes it possible to sweep every one of the sixteen coefficient codes. Each code is combined with data words that include zero, one, minus one and both extremes of the 16-bit range, and with addends that force carries through the full width. Along the way the bench checks the ready timing within each word, that the result holds while the inputs toggle after completion, and that a start issued halfway through a word restarts it cleanly.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;

  // Width of a counter that must reach the value n inclusive.
  function automatic int cnt_width(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/bsmac_fa_cell.sv
// Full adder whose carry is registered and fed back to its own carry input.
module bsmac_fa_cell #(
  parameter logic CARRY_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic a,
  input  logic b,
  output logic sum
);

  logic carry_q;
  logic carry_d;

  assign sum = a ^ b ^ carry_q;

  always_comb begin
    carry_d = carry_q;
    if (clr) begin
      carry_d = CARRY_INIT;
    end else if (en) begin
      carry_d = (a & b) | (a & carry_q) | (b & carry_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= CARRY_INIT;
    end else begin
      carry_q <= carry_d;
    end
  end

  // R9: two zero inputs leave no carry for the next bit-time
  a_r9_carry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !a && !b) |=> (carry_q == 1'b0));

  // R9: two one inputs always produce a carry for the next bit-time
  a_r9_carry_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && a && b) |=> (carry_q == 1'b1));

endmodule

// File: rtl/bsmac_serial_mult.sv
// Bit-serial multiplier: serial data times parallel coefficient.
// One AND gate and one carry-feedback full adder per coefficient bit.
module bsmac_serial_mult #(
  parameter int COEF_W      = 4,
  parameter bit COEF_SIGNED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [COEF_W-1:0] coef,
  input  logic              data_bit,
  output logic              prod_bit
);

  localparam int DLY_N = COEF_W - 1;

  logic [COEF_W-1:0] x_tap;
  logic [DLY_N:1]    x_dly_q;
  logic [DLY_N:1]    x_dly_d;
  logic [COEF_W:0]   chain;

  // Data delay line: x_tap[j] is the data bit from j bit-times earlier.
  assign x_tap[0] = data_bit;
  assign x_tap[COEF_W-1:1] = x_dly_q;

  always_comb begin
    x_dly_d = x_dly_q;
    if (clr) begin
      x_dly_d = '0;
    end else if (en) begin
      x_dly_d = x_tap[DLY_N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_dly_q <= '0;
    end else begin
      x_dly_q <= x_dly_d;
    end
  end

  assign chain[0] = 1'b0;

  for (genvar j = 0; j < COEF_W; j++) begin : g_stage
    logic pp;
    if (COEF_SIGNED && (j == COEF_W - 1)) begin : g_neg
      // Negative weight: add the inverted shifted operand plus one.
      assign pp = ~(coef[j] & x_tap[j]);
      bsmac_fa_cell #(.CARRY_INIT(1'b1)) u_fa (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .clr   (clr),
        .a     (pp),
        .b     (chain[j]),
        .sum   (chain[j+1])
      );
    end else begin : g_pos
      assign pp = coef[j] & x_tap[j];
      bsmac_fa_cell #(.CARRY_INIT(1'b0)) u_fa (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .clr   (clr),
        .a     (pp),
        .b     (chain[j]),
        .sum   (chain[j+1])
      );
    end
  end

  assign prod_bit = chain[COEF_W];

  // R3: a zero unsigned coefficient yields a zero product stream
  a_r3_zero_coef: assert property (@(posedge clk) disable iff (!rst_n)
    (!COEF_SIGNED && en && !clr && (coef == '0) && $stable(coef) && $past(en))
      |-> (prod_bit == 1'b0));

  // R2: a start empties the data delay line
  a_r2_dly_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (x_dly_q == '0));

endmodule

// File: rtl/bsmac_seq_ctrl.sv
// Bit counter and ready flag for one word of RES_W bit-times.
module bsmac_seq_ctrl #(
  parameter int RES_W = 16,
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic step,
  output logic ready
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(RES_W);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (start) begin
      count_d = '0;
    end else if (count_q < LAST) begin
      count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= LAST;
    end else begin
      count_q <= count_d;
    end
  end

  assign step  = !start && (count_q < LAST);
  assign ready = (count_q == LAST);

  // R2: start always drops ready on the next cycle
  a_r2_start_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  // R7: each busy bit-time advances the counter by one
  a_r7_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !start) |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R8: a finished word stays finished until start
  a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);

endmodule

// File: rtl/bsmac_tap.sv
// Bit-serial multiply-accumulate tap: result = data*coef + addend.
module bsmac_tap #(
  parameter int COEF_W      = 4,
  parameter int RES_W       = 16,
  parameter bit COEF_SIGNED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COEF_W-1:0] coef,
  input  logic              data_bit,
  input  logic              addend_bit,
  output logic              ready,
  output logic [RES_W-1:0]  result
);

  localparam int CNT_W = bsmac_pkg::cnt_width(RES_W);

  logic             step;
  logic             prod_bit;
  logic             sum_bit;
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] res_d;

  bsmac_seq_ctrl #(
    .RES_W (RES_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .step  (step),
    .ready (ready)
  );

  bsmac_serial_mult #(
    .COEF_W      (COEF_W),
    .COEF_SIGNED (COEF_SIGNED)
  ) u_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (step),
    .clr      (start),
    .coef     (coef),
    .data_bit (data_bit),
    .prod_bit (prod_bit)
  );

  // Serial adder joining the product stream with the neighbour's sum.
  bsmac_fa_cell #(.CARRY_INIT(1'b0)) u_add (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step),
    .clr   (start),
    .a     (prod_bit),
    .b     (addend_bit),
    .sum   (sum_bit)
  );

  always_comb begin
    res_d = res_q;
    if (step) begin
      res_d = {sum_bit, res_q[RES_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      res_q <= res_d;
    end
  end

  assign result = res_q;

  // R6: busy bit-times move the register one place toward bit 0
  a_r6_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !start) |=> (result[RES_W-2:0] == $past(result[RES_W-1:1])));

  // R8: a finished result is frozen while start is low
  a_r8_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> $stable(result));

endmodule

// File: tb/bsmac_tap_test.sv
module bsmac_tap_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  coef;
  logic        data_bit;
  logic        addend_bit;
  logic        ready_u;
  logic        ready_s;
  logic [15:0] result_u;
  logic [15:0] result_s;

  int n_checks;
  int n_fail;
  bit finished;

  bsmac_tap #(.COEF_W(4), .RES_W(16), .COEF_SIGNED(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .coef(coef),
    .data_bit(data_bit), .addend_bit(addend_bit),
    .ready(ready_u), .result(result_u)
  );

  bsmac_tap #(.COEF_W(4), .RES_W(16), .COEF_SIGNED(1'b1)) uut_s (
    .clk(clk), .rst_n(rst_n), .start(start), .coef(coef),
    .data_bit(data_bit), .addend_bit(addend_bit),
    .ready(ready_s), .result(result_s)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_unsigned(input logic [15:0] x, input logic [3:0] c,
                                               input logic [15:0] a);
    int v;
    v = int'($signed(x)) * int'(c) + int'(a);
    return v[15:0];
  endfunction

  function automatic logic [15:0] exp_signed(input logic [15:0] x, input logic [3:0] c,
                                             input logic [15:0] a);
    int v;
    v = int'($signed(x)) * int'($signed(c)) + int'(a);
    return v[15:0];
  endfunction

  // Runs one word; called just after a falling edge.
  task automatic run_word(input logic [15:0] x, input logic [3:0] c, input logic [15:0] a);
    bit low_ok;
    start = 1'b1;
    coef  = c;
    @(negedge clk);
    start = 1'b0;
    low_ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      data_bit   = x[i];
      addend_bit = a[i];
      if (ready_u !== 1'b0 || ready_s !== 1'b0) low_ok = 1'b0;
      @(negedge clk);
    end
    check("R7 ready low during word", {31'd0, low_ok}, 32'd1);
    check("R7 ready after 16 bits", {30'd0, ready_u, ready_s}, 32'd3);
    check("R3 R5 unsigned result", {16'd0, result_u}, {16'd0, exp_unsigned(x, c, a)});
    check("R4 R5 signed result", {16'd0, result_s}, {16'd0, exp_signed(x, c, a)});
  endtask

  function automatic logic [15:0] pick_data(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h7FFF;
      4: return 16'h8000;
      5: return 16'h5555;
      default: begin
        int v;
        v = k * k * 2731 + k * 37;
        return v[15:0];
      end
    endcase
  endfunction

  initial begin
    n_checks = 0;
    n_fail = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    start = 1'b0;
    coef = 4'd0;
    data_bit = 1'b0;
    addend_bit = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state out of reset
    check("R1 reset ready", {30'd0, ready_u, ready_s}, 32'd3);
    check("R1 reset result", {result_u, result_s}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: a single data bit of weight one lands in result bit 0
    run_word(16'h0001, 4'd1, 16'h0000);
    check("R6 lsb position", {16'd0, result_u}, 32'h0001);
    // R6: addend alone passes straight through in order
    run_word(16'h0000, 4'd0, 16'hA5C3);
    check("R6 addend order", {16'd0, result_u}, 32'hA5C3);

    // R3 R4 R5: sweep every coefficient code
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 12; k++) begin
        int av;
        av = k * 1237 - 500 + c * 4099;
        run_word(pick_data(k), 4'(c), av[15:0]);
      end
    end

    // R8: inputs toggled after completion change nothing
    run_word(16'h1234, 4'd9, 16'h0F0F);
    begin
      logic [15:0] held_u;
      logic [15:0] held_s;
      bit steady;
      held_u = result_u;
      held_s = result_s;
      steady = 1'b1;
      for (int i = 0; i < 8; i++) begin
        data_bit = i[0];
        addend_bit = ~i[0];
        coef = 4'(i * 3);
        @(negedge clk);
        if (result_u !== held_u || result_s !== held_s || ready_u !== 1'b1) steady = 1'b0;
      end
      check("R8 inputs ignored when done", {31'd0, steady}, 32'd1);
    end

    // R2: abandon a word half way, then restart
    start = 1'b1;
    coef = 4'd15;
    @(negedge clk);
    start = 1'b0;
    check("R2 ready drops on start", {30'd0, ready_u, ready_s}, 32'd0);
    for (int i = 0; i < 7; i++) begin
      data_bit = 1'b1;
      addend_bit = 1'b1;
      @(negedge clk);
    end
    run_word(16'hFFF0, 4'd11, 16'h0003);
    check("R2 restart clean unsigned", {16'd0, result_u},
          {16'd0, exp_unsigned(16'hFFF0, 4'd11, 16'h0003)});

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule